// File: doc/BRIEF.md
# DRAM Forced Refresh Controller

This block schedules DRAM refresh and generates the row strobes for it. A slow periodic input, the refresh-window clock, divides time into windows. A separate strobe-timing clock sets the length of the refresh RAS pulse. The block runs on one system clock. It samples both slow clocks through synchronisers and works from their edges. If a refresh window's high phase passes with no completed refresh, the block pulls a shared open-drain request line low when the window clock falls. The host then grants a refresh by taking the active-low refresh-enable input low.

Two things can happen once refresh-enable is low, depending on the window clock. If the window clock is high at that moment, the block is in hidden (externally timed) refresh: all four RAS outputs follow the incoming RAS strobe, and each rising edge of that strobe counts as one refresh. If the window clock is low, the block runs a forced refresh. It waits two falling edges of the strobe-timing clock, pulls every RAS low, then holds them low for two further falling edges. Raising refresh-enable during this sequence ends it early.

While in either refresh mode the row address bus carries the internal refresh row counter. The counter steps at the end of every refresh. Holding the shared request line low from outside, while the block itself is not driving it, clears the counter. Outside refresh the block passes the host row address through and steers the incoming RAS strobe to one selected bank.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, all RAS outputs are 1 (inactive), `req_oe_o` is 0 (line released) and the refresh row counter is 0.
- R2: With `rfsh_n_i` high (normal mode), `ras_n_o[bank_sel_i]` equals `rasin_n_i`, every other RAS output is 1, and `addr_o` equals `row_addr_i`.
- R3: If the synchronised window clock is high when `rfsh_n_i` is sampled low, the block enters hidden refresh. All RAS outputs equal `rasin_n_i`, and every 0-to-1 transition of `rasin_n_i` completes one refresh.
- R4: On a falling edge of the synchronised window clock, `req_oe_o` becomes 1 unless a refresh completed since that clock's last rising edge. A rising edge of the window clock clears that record.
- R5: From the cycle after `rfsh_n_i` is sampled low until the block returns to normal mode, `addr_o` carries the refresh row counter.
- R6: If the window clock is low when `rfsh_n_i` is sampled low, a forced refresh starts. All RAS outputs go to 0 after the second falling edge of the strobe-timing clock, and return to 1 after two more falling edges.
- R7: An active request (`req_oe_o` = 1) is withdrawn in the same cycle in which the forced-refresh RAS outputs go to 0.
- R8: Raising `rfsh_n_i` during a forced refresh returns the block to normal mode on the next clock. If the RAS pulse had already started, the refresh counts as completed.
- R9: The refresh row counter increments by one at each completed refresh and wraps from its maximum value to 0.
- R10: If the request line is observed low for two consecutive synchronised samples while the block has not driven it for the last four cycles, the counter is cleared to 0. The block's own request never clears the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rfck_i | input | 1 | Refresh-window clock (asynchronous, slow) |
| rgck_i | input | 1 | Strobe-timing clock for forced refresh (asynchronous) |
| rasin_n_i | input | 1 | Incoming active-low RAS strobe |
| bank_sel_i | input | 2 | Bank steered in normal mode |
| rfsh_n_i | input | 1 | Active-low refresh enable / grant |
| req_line_i | input | 1 | Observed level of the wired-AND request line |
| row_addr_i | input | 10 | Host row address for normal accesses |
| req_oe_o | output | 1 | 1 = block pulls the request line low |
| ras_n_o | output | 4 | Active-low RAS per bank |
| addr_o | output | 10 | Row address output |

## Verification
Several properties are checked on every cycle. In normal mode at most one bank strobe is active. During a forced refresh all strobes move together, and the address holds steady while they are low. The request is never active while the forced pulse is low. The counter only steps by one or returns to zero. Early exit always reaches normal mode. Only the bench scenarios can show the timing counted in strobe-clock edges, the request being suppressed after a hidden refresh, the clearing through the shared line, and the counter wrapping after a full cycle of refreshes.

// File: rtl/drfc_pkg.sv
package drfc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_EXT  = 3'd1,
    ST_WAIT = 3'd2,
    ST_LOW  = 3'd3,
    ST_DONE = 3'd4
  } drfc_state_e;
endpackage

// File: rtl/drfc_sync_edge.sv
// Multi-stage synchroniser; exposes the settled level and the sample before it.
module drfc_sync_edge #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic prev_o
);
  logic [STAGES-1:0] sh_q, sh_d;
  logic              prev_q;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sh_q   <= sh_d;
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/drfc_row_ctr.sv
// Refresh row counter: clear has priority over increment, wraps naturally.
module drfc_row_ctr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import drfc_pkg::*;
#(
  parameter int AW            = 10,
  parameter int NB            = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int FALLS_TO_LOW  = 2,
  parameter int FALLS_LOW     = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rfck_i,
  input  logic                  rgck_i,
  input  logic                  rasin_n_i,
  input  logic [$clog2(NB)-1:0] bank_sel_i,
  input  logic                  rfsh_n_i,
  input  logic                  req_line_i,
  input  logic [AW-1:0]         row_addr_i,
  output logic                  req_oe_o,
  output logic [NB-1:0]         ras_n_o,
  output logic [AW-1:0]         addr_o
);
  localparam int BSW   = $clog2(NB);
  localparam int ECMAX = (FALLS_TO_LOW > FALLS_LOW) ? FALLS_TO_LOW : FALLS_LOW;
  localparam int ECW   = $clog2(ECMAX + 1);
  localparam logic [ECW-1:0] LAST_WAIT = ECW'(FALLS_TO_LOW - 1);
  localparam logic [ECW-1:0] LAST_LOW  = ECW'(FALLS_LOW - 1);
  localparam int HOLD  = SYNC_STAGES + 2;
  localparam int NSYNC = 3;            // 0: window clock, 1: strobe clock, 2: request line
  localparam logic [NSYNC-1:0] SRST = 3'b100;

  // ---------------- synchronisers ----------------
  logic [NSYNC-1:0] s_in, s_lvl, s_prev;
  assign s_in = {req_line_i, rgck_i, rfck_i};

  for (genvar gi = 0; gi < NSYNC; gi++) begin : g_sync
    drfc_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(SRST[gi])) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (s_in[gi]),
      .lvl_o  (s_lvl[gi]),
      .prev_o (s_prev[gi])
    );
  end

  logic rfck_lvl, rfck_rise, rfck_fall, gen_fall, line_low;
  assign rfck_lvl  = s_lvl[0];
  assign rfck_rise = s_lvl[0] & ~s_prev[0];
  assign rfck_fall = ~s_lvl[0] & s_prev[0];
  assign gen_fall  = ~s_lvl[1] & s_prev[1];
  assign line_low  = ~s_lvl[2] & ~s_prev[2];

  // ---------------- state ----------------
  drfc_state_e      st_q, st_d;
  logic [ECW-1:0]   ecnt_q, ecnt_d;
  logic             done_q, done_d;
  logic             req_q, req_d;
  logic             rasin_q;
  logic [HOLD-1:0]  oeh_q, oeh_d;
  logic             ref_done, enter_low, cnt_clr;
  logic [AW-1:0]    cnt_q;
  logic             rasin_rise;

  assign rasin_rise = ~rasin_q & rasin_n_i;

  always_comb begin
    st_d      = st_q;
    ecnt_d    = ecnt_q;
    ref_done  = 1'b0;
    enter_low = 1'b0;
    case (st_q)
      ST_IDLE: if (!rfsh_n_i) begin
        st_d   = rfck_lvl ? ST_EXT : ST_WAIT;
        ecnt_d = '0;
      end
      ST_EXT: begin
        if (rfsh_n_i)        st_d = ST_IDLE;
        else if (rasin_rise) ref_done = 1'b1;
      end
      ST_WAIT: begin
        if (rfsh_n_i) st_d = ST_IDLE;
        else if (gen_fall) begin
          if (ecnt_q == LAST_WAIT) begin
            st_d      = ST_LOW;
            ecnt_d    = '0;
            enter_low = 1'b1;
          end else begin
            ecnt_d = ecnt_q + 1'b1;
          end
        end
      end
      ST_LOW: begin
        if (rfsh_n_i) begin
          st_d     = ST_IDLE;
          ref_done = 1'b1;
        end else if (gen_fall) begin
          if (ecnt_q == LAST_LOW) begin
            st_d     = ST_DONE;
            ref_done = 1'b1;
          end else begin
            ecnt_d = ecnt_q + 1'b1;
          end
        end
      end
      ST_DONE: if (rfsh_n_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // Window bookkeeping and request generation
  always_comb begin
    done_d = done_q;
    if (rfck_rise) done_d = 1'b0;
    if (ref_done)  done_d = 1'b1;
    req_d = req_q;
    if (rfck_fall && !done_q && !ref_done) req_d = 1'b1;
    if (ref_done || enter_low)             req_d = 1'b0;
    oeh_d   = {oeh_q[HOLD-2:0], req_q};
    cnt_clr = line_low & ~req_q & ~(|oeh_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ecnt_q  <= '0;
      done_q  <= 1'b0;
      req_q   <= 1'b0;
      rasin_q <= 1'b1;
      oeh_q   <= '0;
    end else begin
      st_q    <= st_d;
      ecnt_q  <= ecnt_d;
      done_q  <= done_d;
      req_q   <= req_d;
      rasin_q <= rasin_n_i;
      oeh_q   <= oeh_d;
    end
  end

  drfc_row_ctr #(.W(AW)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cnt_clr),
    .inc_i (ref_done),
    .cnt_o (cnt_q)
  );

  // ---------------- outputs ----------------
  always_comb begin
    ras_n_o = {NB{1'b1}};
    if (rst_n) begin
      case (st_q)
        ST_IDLE: for (int b = 0; b < NB; b++)
                   ras_n_o[b] = (bank_sel_i == BSW'(b)) ? rasin_n_i : 1'b1;
        ST_EXT:  ras_n_o = {NB{rasin_n_i}};
        ST_LOW:  ras_n_o = '0;
        default: ras_n_o = {NB{1'b1}};
      endcase
    end
  end

  assign addr_o   = (st_q == ST_IDLE) ? row_addr_i : cnt_q;
  assign req_oe_o = req_q;
endmodule

// File: rtl/drfc_checker.sv
module drfc_checker
  import drfc_pkg::*;
#(
  parameter int AW = 10,
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rfsh_n_i,
  input logic          req_oe_o,
  input drfc_state_e   st,
  input logic [AW-1:0] cnt,
  input logic [NB-1:0] ras_n_o,
  input logic [AW-1:0] addr_o
);
  logic forced;
  assign forced = (st == ST_WAIT) || (st == ST_LOW) || (st == ST_DONE);

  a_r2_one_bank_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> ($countones(~ras_n_o) <= 1));

  a_r6_strobes_together: assert property (@(posedge clk) disable iff (!rst_n)
    forced |-> (ras_n_o == '0 || ras_n_o == {NB{1'b1}}));

  a_r6_low_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == ST_LOW) |-> ($past(st) == ST_WAIT));

  a_r5_addr_steady_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOW && $past(st == ST_LOW)) |-> $stable(addr_o));

  a_r7_no_req_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOW) |-> !req_oe_o);

  a_r8_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (forced && rfsh_n_i) |=> (st == ST_IDLE));

  a_r9_ctr_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> (cnt == '0 || cnt == $past(cnt) + {{(AW-1){1'b0}}, 1'b1}));
endmodule

bind dram_refresh_ctrl drfc_checker #(.AW(AW), .NB(NB)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rfsh_n_i (rfsh_n_i),
  .req_oe_o (req_oe_o),
  .st       (st_q),
  .cnt      (cnt_q),
  .ras_n_o  (ras_n_o),
  .addr_o   (addr_o)
);

// File: tb/sim_dram_refresh_ctrl.sv
module sim_dram_refresh_ctrl;
  localparam int CLK_P = 10;
  localparam int AW    = 10;
  localparam int NB    = 4;
  localparam int KRAS  = 0;
  localparam int KREQ  = 1;
  localparam int ALL1  = (1 << NB) - 1;

  logic clk, rst_n, rfck, rgck, rasin_n, rfsh_n, ext_pull;
  logic [1:0]    bank_sel;
  logic [AW-1:0] row_addr;
  logic          req_oe, req_line;
  logic [NB-1:0] ras_n;
  logic [AW-1:0] addr;

  assign req_line = ~(req_oe | ext_pull);

  dram_refresh_ctrl #(.AW(AW), .NB(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .rfck_i(rfck), .rgck_i(rgck),
    .rasin_n_i(rasin_n), .bank_sel_i(bank_sel), .rfsh_n_i(rfsh_n),
    .req_line_i(req_line), .row_addr_i(row_addr), .req_oe_o(req_oe),
    .ras_n_o(ras_n), .addr_o(addr)
  );

  typedef struct { int kind; int val; int g; string tag; } exp_t;
  exp_t expq[$];
  int checks = 0, fails = 0, gfalls = 0, gmark = 0;
  bit finished = 0;
  logic [NB-1:0] ras_prev;
  logic          oe_prev;

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(int kind, int val, int g, string tag);
    exp_t e;
    e.kind = kind; e.val = val; e.g = g; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic observe(int kind, int val, int g);
    exp_t e;
    if (expq.size() == 0) begin
      chk(1'b0, "R2", (kind == KRAS) ? "unexpected RAS change" : "unexpected request change", val, -1);
    end else begin
      e = expq.pop_front();
      chk(e.kind == kind && e.val == val, e.tag, "event value", val, e.val);
      if (e.g >= 0) chk(e.g == g, e.tag, "strobe-clock falls at event", g, e.g);
    end
  endtask

  // Monitor: turns output changes into observed items and scores them
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (ras_n !== ras_prev) begin
        observe(KRAS, int'(ras_n), gfalls - gmark);
        ras_prev = ras_n;
      end
      if (req_oe !== oe_prev) begin
        observe(KREQ, int'(req_oe), -1);
        oe_prev = req_oe;
      end
    end
  end

  // Strobe-timing clock: period of eight system clocks
  initial begin
    rgck = 1'b0;
    forever begin
      repeat (4) @(posedge clk);
      #1;
      rgck = ~rgck;
      if (!rgck) gfalls++;
    end
  end

  task automatic wait_ras(int val, string tag);
    int n = 0;
    while (int'(ras_n) != val && n < 100) begin tick(1); n++; end
    chk(int'(ras_n) == val, tag, "RAS reached level", int'(ras_n), val);
  endtask

  task automatic forced(bit with_req, bit abort, int exp_addr);
    push(KRAS, 0, 2, "R6");
    if (with_req) push(KREQ, 0, -1, "R7");
    push(KRAS, ALL1, 2 + (abort ? 0 : 2), abort ? "R8" : "R6");
    @(posedge rgck);
    tick(1);
    rfsh_n = 1'b0;
    gmark  = gfalls;
    wait_ras(0, "R6");
    chk(int'(addr) == exp_addr, "R5", "refresh row address", int'(addr), exp_addr);
    if (with_req) chk(req_oe == 1'b0, "R7", "request during pulse", int'(req_oe), 0);
    if (abort) begin
      tick(1);
      rfsh_n = 1'b1;
      tick(3);
      chk(int'(ras_n) == ALL1, "R8", "RAS after early end", int'(ras_n), ALL1);
    end else begin
      wait_ras(ALL1, "R6");
      tick(1);
      rfsh_n = 1'b1;
      tick(2);
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; rfck = 1'b0; rasin_n = 1'b1; rfsh_n = 1'b1;
    ext_pull = 1'b0; bank_sel = 2'd0; row_addr = '0;
    ras_prev = '1; oe_prev = 1'b0;
    tick(2);
    chk(int'(ras_n) == ALL1, "R1", "RAS in reset", int'(ras_n), ALL1);
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk(int'(ras_n) == ALL1, "R1", "RAS after reset", int'(ras_n), ALL1);
    chk(req_oe == 1'b0, "R1", "request after reset", int'(req_oe), 0);

    // R2: normal-mode steering
    row_addr = 10'h155; bank_sel = 2'd2;
    tick(1);
    chk(int'(addr) == 'h155, "R2", "pass-through address", int'(addr), 'h155);
    push(KRAS, 'b1011, -1, "R2"); rasin_n = 1'b0; tick(2);
    push(KRAS, ALL1,   -1, "R2"); rasin_n = 1'b1; tick(2);
    bank_sel = 2'd0;
    push(KRAS, 'b1110, -1, "R2"); rasin_n = 1'b0; tick(2);
    push(KRAS, ALL1,   -1, "R2"); rasin_n = 1'b1; tick(2);

    // R4: window passes without refresh
    rfck = 1'b1; tick(10);
    push(KREQ, 1, -1, "R4");
    rfck = 1'b0; tick(10);
    chk(req_oe == 1'b1, "R4", "request after empty window", int'(req_oe), 1);

    // R6/R7/R5: full forced refresh, counter 0 (R1)
    forced(1'b1, 1'b0, 0);

    // R4: new window, done record cleared on rise
    rfck = 1'b1; tick(10);
    push(KREQ, 1, -1, "R4");
    rfck = 1'b0; tick(10);
    chk(req_oe == 1'b1, "R4", "request in next window", int'(req_oe), 1);

    // R8 early end; R10: own request left the counter at 1
    forced(1'b1, 1'b1, 1);

    // R3: hidden refresh while window clock high, counter now 2 (R9)
    rfck = 1'b1; tick(6);
    rfsh_n = 1'b0; tick(3);
    chk(int'(addr) == 2, "R9", "counter after aborted pulse", int'(addr), 2);
    push(KRAS, 0, -1, "R3"); rasin_n = 1'b0; tick(2);
    push(KRAS, ALL1, -1, "R3"); rasin_n = 1'b1; tick(3);
    chk(int'(addr) == 3, "R9", "counter after hidden refresh", int'(addr), 3);
    rfsh_n = 1'b1; tick(3);
    rfck = 1'b0; tick(12);
    chk(req_oe == 1'b0, "R4", "no request after hidden refresh", int'(req_oe), 0);

    // R10: external pull clears counter
    ext_pull = 1'b1; tick(6);
    ext_pull = 1'b0; tick(6);
    rfck = 1'b1; tick(6);
    rfsh_n = 1'b0; tick(3);
    chk(int'(addr) == 0, "R10", "counter after external pull", int'(addr), 0);

    // R9: full wrap through hidden refreshes
    for (int i = 0; i < (1 << AW); i++) begin
      push(KRAS, 0, -1, "R3"); rasin_n = 1'b0; tick(2);
      push(KRAS, ALL1, -1, "R3"); rasin_n = 1'b1; tick(2);
      if (i == 0) chk(int'(addr) == 1, "R9", "counter after first step", int'(addr), 1);
    end
    tick(1);
    chk(int'(addr) == 0, "R9", "counter after wrap", int'(addr), 0);
    rfsh_n = 1'b1; tick(4);
    chk(int'(addr) == 'h155, "R2", "address back to host", int'(addr), 'h155);

    tick(5);
    chk(expq.size() == 0, "R6", "expected events left", expq.size(), 0);
    summary();
  end
endmodule